// File: doc/BRIEF.md
# Asynchronous Byte-Wide Static RAM Model

This block is a synthesizable stand-in for an external byte-wide asynchronous static RAM. It can take the place of the real chip in a testbench or an on-chip experiment. A fast reference clock samples the active-low select, output-enable and write-enable controls and the address and data buses. The model turns those samples into the behaviour of the real part: an addressed read, a write, a selected state with the outputs off, and an unselected standby state.

The tristate drivers of the real part become a `dataOe` flag next to a separate data-out bus. A parent that has a real bidirectional pin can use `dataOe` to control its driver. A write is the stretch of samples in which select and write-enable are both low. It ends on the first sample in which either of them has returned high, and it stores the address and data from the last sample inside that stretch. Storage depth is `2**ADDR_W` words. The default is kept small for simulation, and a full-size part sets `ADDR_W` to 19. The storage array has no reset.

Top module: `async_sram_model`

## Requirements
- R1: The store holds `2**ADDR_W` independently addressable 8-bit words, from address 0 up to address `2**ADDR_W-1`.
- R2: While `ceN` is 1, `standby` is 1 and `dataOe` is 0 whatever `oeN` and `weN` are, and a low `weN` changes no stored word.
- R3: While `ceN`=0, `weN`=1 and `oeN`=0, `dataOe` is 1, `standby` is 0 and `dataOut` equals the word stored at `addr`.
- R4: While `ceN`=0 and `weN`=0, `dataOe` is 0 for either value of `oeN` and `standby` is 0.
- R5: While `ceN`=0, `oeN`=1 and `weN`=1, `dataOe` is 0 and `standby` is 0.
- R6: A write that ends because `weN` returns to 1 stores the data and address sampled on the last clock edge at which `ceN` and `weN` were both 0.
- R7: A write that ends because `ceN` returns to 1 also stores its last sampled data and address.
- R8: When `ceN` and `weN` return to 1 on the same sample, the write is stored and `dataOe` stays 0.
- R9: A change of `addr` during a read changes `dataOut` in the same cycle, with no new enable edge.
- R10: If address and data change inside one write window, only the final sampled pair is stored and earlier addresses keep their contents.
- R11: A write window that ends while `rst_n` is 0 stores nothing, and reset does not clear the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Active-low synchronous reset of the sampling state |
| ceN | input | 1 | Active-low chip select |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Word address |
| dataIn | input | DATA_W | Write data |
| dataOut | output | DATA_W | Read data, zero when not driving |
| dataOe | output | 1 | High when the model drives the data bus |
| standby | output | 1 | High when the model is unselected |

## Verification
The assertions assume that the controls are already synchronous to `clk`: every level on `ceN`, `weN` and `oeN` is treated as a held sample, and no glitch shorter than one period is expected. The stimulus changes inputs only one nanosecond after a rising edge and keeps every level for at least a full cycle. It covers each of the three ways a write can end, holding `oeN` low through some writes. Reads go only to addresses that have already been written, so the comparison with the reference never involves an uninitialised word.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY  = 2'd0,
    MODE_SELECTED = 2'd1,
    MODE_READ     = 2'd2,
    MODE_WRITE    = 2'd3
  } sramMode_e;

  typedef struct packed {
    logic capture;
    logic commit;
    logic drive;
  } sramStrobe_t;

endpackage

// File: rtl/sram_model_ctrl.sv
module sram_model_ctrl
  import sram_model_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ceN,
  input  logic        oeN,
  input  logic        weN,
  output sramStrobe_t strobe,
  output logic        standby
);

  sramMode_e mode;
  logic      winNow;
  logic      winPrev;

  // Priority: deselect first, then write, then read
  always_comb begin
    if (ceN)       mode = MODE_STANDBY;
    else if (!weN) mode = MODE_WRITE;
    else if (!oeN) mode = MODE_READ;
    else           mode = MODE_SELECTED;
  end

  assign winNow = (mode == MODE_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) winPrev <= 1'b0;
    else        winPrev <= winNow;
  end

  always_comb begin
    strobe.capture = winNow & rst_n;
    strobe.commit  = winPrev & ~winNow & rst_n;
    strobe.drive   = (mode == MODE_READ);
  end

  assign standby = (mode == MODE_STANDBY);

  // R6: a commit needs a fresh window before the next one
  a_r6_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commit |=> !strobe.commit);

  // R10: a commit is always preceded by a capture on the previous edge
  a_r10_commit_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commit |-> $past(strobe.capture));

endmodule

// File: rtl/sram_model_data.sv
module sram_model_data
  import sram_model_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sramStrobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [ADDR_W-1:0] addrHold;
  logic [DATA_W-1:0] dataHold;
  logic [DATA_W-1:0] rdWord;

  // Last sample inside the write window
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrHold <= '0;
      dataHold <= '0;
    end else if (strobe.capture) begin
      addrHold <= addr;
      dataHold <= dataIn;
    end
  end

  // Array has no reset so its contents survive rst_n
  always_ff @(posedge clk) begin
    if (strobe.commit) store[addrHold] <= dataHold;
  end

  assign rdWord  = store[addr];
  assign dataOe  = strobe.drive;
  assign dataOut = strobe.drive ? rdWord : '0;

  // R4: never drive while a write window is open
  a_r4_quiet_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |-> !dataOe);

endmodule

// File: rtl/async_sram_model.sv
module async_sram_model
  import sram_model_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              standby
);

  sramStrobe_t strobe;

  sram_model_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ceN     (ceN),
    .oeN     (oeN),
    .weN     (weN),
    .strobe  (strobe),
    .standby (standby)
  );

  sram_model_data #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .addr    (addr),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );

  // R2: standby and driving are exclusive
  a_r2_standby_silent: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !dataOe);

  // R3: a read state drives the bus while selected
  a_r3_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!ceN && weN && !oeN) |-> (dataOe && !standby));

  // R5: selected with outputs off stays active and silent
  a_r5_selected_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ceN && weN && oeN) |-> (!dataOe && !standby));

  // R8: joint rise of select and write-enable leaves the bus off
  a_r8_joint_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ceN) && $rose(weN)) |-> !dataOe);

endmodule

// File: tb/async_sram_model_test.sv
`timescale 1ns/1ps
module async_sram_model_test;

  localparam int AW = 10;
  localparam int DW = 8;
  localparam int TOP = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ceN = 1'b1;
  logic          oeN = 1'b1;
  logic          weN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic          dataOe;
  logic          standby;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  async_sram_model #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .standby(standby)
  );

  // Behavioural reference: written words and the open window
  logic [DW-1:0] refMem [int];
  bit            refOpen = 1'b0;
  int            refAddr = 0;
  int            refData = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      refOpen = 1'b0;
    end else begin
      if (refOpen && !(!ceN && !weN)) refMem[refAddr] = DW'(refData);
      refOpen = !ceN && !weN;
      if (refOpen) begin
        refAddr = int'(addr);
        refData = int'(dataIn);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!done) begin
      bit    expOe;
      string tag;
      expOe = !ceN && weN && !oeN;
      tag = ceN ? "R2" : (!weN ? "R4" : (!oeN ? "R3" : "R5"));
      chk(dataOe == expOe, tag, int'(dataOe), int'(expOe));
      chk(standby == ceN, tag, int'(standby), int'(ceN));
      if (expOe && refMem.exists(int'(addr)))
        chk(dataOut == refMem[int'(addr)], "R3", int'(dataOut), int'(refMem[int'(addr)]));
    end
  end

  task automatic step(input bit c, input bit o, input bit w,
                      input int a, input int d);
    @(posedge clk);
    #1;
    ceN = c; oeN = o; weN = w;
    addr = AW'(a); dataIn = DW'(d);
  endtask

  task automatic readAt(input int a, input int exp, input string tag);
    step(0, 0, 1, a, 0);
    @(negedge clk);
    chk(dataOe == 1'b1, tag, int'(dataOe), 1);
    chk(dataOut == DW'(exp), tag, int'(dataOut), exp);
  endtask

  // endMode: 0 write-enable rises, 1 select rises, 2 both rise
  task automatic writeWin(input int a, input int d, input int endMode, input bit o);
    step(0, o, 0, a, d);
    step(0, o, 0, a, d);
    case (endMode)
      0:       step(0, o, 1, a, d);
      1:       step(1, o, 0, a, d);
      default: step(1, o, 1, a, d);
    endcase
    step(1, 1, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(standby == 1'b1 && dataOe == 1'b0, "R2 reset", int'({standby, dataOe}), 2);
    #1 rst_n = 1'b1;

    // R6: ended by write-enable
    writeWin(0, 8'h3C, 0, 1'b1);
    readAt(0, 8'h3C, "R6");
    // R7 / R1: ended by select, at the top address
    writeWin(TOP, 8'hC3, 1, 1'b1);
    readAt(TOP, 8'hC3, "R7");
    readAt(0, 8'h3C, "R1 low");
    readAt(TOP, 8'hC3, "R1 high");

    // R8 and R4: joint rise with output enable held low
    step(0, 0, 0, 9, 8'h5A);
    @(negedge clk);
    chk(dataOe == 1'b0, "R4 oe low", int'(dataOe), 0);
    step(0, 0, 0, 9, 8'h5A);
    step(1, 0, 1, 9, 8'h5A);
    @(negedge clk);
    chk(dataOe == 1'b0, "R8 bus off", int'(dataOe), 0);
    step(1, 1, 1, 0, 0);
    readAt(9, 8'h5A, "R8 stored");

    // R2: write-enable while unselected is ignored
    step(1, 0, 0, 0, 8'hFF);
    step(1, 0, 0, 0, 8'hFF);
    step(1, 0, 1, 0, 8'hFF);
    readAt(0, 8'h3C, "R2 ignored");

    // R5: selected, outputs off
    step(0, 1, 1, 0, 0);
    @(negedge clk);
    chk(dataOe == 1'b0 && standby == 1'b0, "R5", int'({dataOe, standby}), 0);

    // R9: address change during a read
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 9, 0);
    @(negedge clk);
    chk(dataOut == 8'h5A, "R9", int'(dataOut), 8'h5A);

    // R10: changing pair inside one window
    writeWin(20, 8'h77, 0, 1'b1);
    step(0, 1, 0, 20, 8'h01);
    step(0, 1, 0, 21, 8'h02);
    step(0, 1, 1, 21, 8'h02);
    readAt(20, 8'h77, "R10 earlier");
    readAt(21, 8'h02, "R10 final");

    // R11: window ending in reset stores nothing; contents survive
    writeWin(5, 8'hA5, 0, 1'b1);
    step(0, 1, 0, 5, 8'h11);
    #1 rst_n = 1'b0;
    step(0, 1, 0, 5, 8'h11);
    step(0, 1, 1, 5, 8'h11);
    step(1, 1, 1, 0, 0);
    #1 rst_n = 1'b1;
    readAt(5, 8'hA5, "R11");
    readAt(21, 8'h02, "R11 kept");

    step(1, 1, 1, 0, 0);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule